// File: doc/BRIEF.md
# Instruction Execute Stage

This block is the execute stage of a 16-bit multi-cycle processor. It receives one instruction word together with the two source register values (first and second operand) and the incremented program counter. From the opcode it works out the operands and the operation, and it produces two results: an ALU result (add, bitwise and, bitwise invert) and a target address (branch, jump or memory address).

The target address is the sum of a base and an extended offset. The base is the incremented program counter, the first register operand, or zero. The offset is one of several immediate fields cut from fixed bit ranges of the instruction, or zero. Most of these fields are sign-extended. The trap vector field is zero-extended.

Work enters through a valid/ready input handshake and leaves through a registered valid/ready output. The input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure from `out_ready` stalls acceptance without losing a result. The results of an accepted instruction appear one clock edge later and stay stable until they are consumed.

Top module: `exec_stage`

## Requirements
- R1: After reset, `out_valid` is 0, `aluout` and `pcout` are 0, and `in_ready` is 1.
- R2: For opcode 0001 (bits 15:12) `aluout` becomes first operand + second value. The second value is `vsr2` when bit 5 is 0. When bit 5 is 1 it is bits 4:0 sign-extended to 16 bits.
- R3: For opcode 0101 `aluout` becomes first operand AND second value, with the same bit-5 selection as R2.
- R4: For opcode 1001 `aluout` becomes the bitwise inverse of `vsr1`.
- R5: For opcodes 0000, 0010, 0011, 1010, 1011 and 1110, `pcout` becomes `npc` + sign-extended bits 8:0.
- R6: For opcode 0100, `pcout` depends on bit 11. When bit 11 is 1 it becomes `npc` + sign-extended bits 10:0. When bit 11 is 0 it becomes `vsr1`.
- R7: For opcode 1100 `pcout` becomes `vsr1`. For opcodes 0110 and 0111 it becomes `vsr1` + sign-extended bits 5:0.
- R8: For opcode 1111 `pcout` becomes bits 7:0 zero-extended to 16 bits.
- R9: An accepted instruction whose opcode is not 0001, 0101 or 1001 leaves `aluout` unchanged. Opcodes 0001, 0101, 1001 and any opcode not named in R5 to R8 load `pcout` with `npc`.
- R10: `in_ready` equals `!out_valid || out_ready`. An input transfer sets `out_valid` and loads the results on that edge. While `out_valid` is 1 and `out_ready` is 0, `aluout`, `pcout` and `out_valid` hold.
- R11: When the output is consumed (`out_valid` and `out_ready` high) and no new input is transferred, `out_valid` goes to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are presented |
| in_ready | output | 1 | Stage can take an instruction this cycle |
| ir | input | 16 | Instruction word |
| vsr1 | input | 16 | First register operand value |
| vsr2 | input | 16 | Second register operand value |
| npc | input | 16 | Incremented program counter |
| out_valid | output | 1 | Results are held and valid |
| out_ready | input | 1 | Consumer takes the results this cycle |
| aluout | output | 16 | ALU result register |
| pcout | output | 16 | Target address register |

## Verification
`in_ready` is combinational and is due in the same cycle as the stimulus, so the bench checks it one nanosecond after driving the inputs and before the next rising edge. `aluout`, `pcout` and `out_valid` each pass through exactly one register, so they are due right after the rising edge that sees the transfer. The bench samples them one nanosecond after that edge and changes inputs only on falling edges. A bench model updates its expected output register only on the edges it predicts will transfer or drain, so stall and hold cycles are checked to the same timing.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam logic [3:0] OPC_BR   = 4'h0;
  localparam logic [3:0] OPC_ADD  = 4'h1;
  localparam logic [3:0] OPC_LD   = 4'h2;
  localparam logic [3:0] OPC_ST   = 4'h3;
  localparam logic [3:0] OPC_JSR  = 4'h4;
  localparam logic [3:0] OPC_AND  = 4'h5;
  localparam logic [3:0] OPC_LDR  = 4'h6;
  localparam logic [3:0] OPC_STR  = 4'h7;
  localparam logic [3:0] OPC_NOT  = 4'h9;
  localparam logic [3:0] OPC_LDI  = 4'hA;
  localparam logic [3:0] OPC_STI  = 4'hB;
  localparam logic [3:0] OPC_JMP  = 4'hC;
  localparam logic [3:0] OPC_LEA  = 4'hE;
  localparam logic [3:0] OPC_TRAP = 4'hF;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_AND = 2'd1,
    ALU_NOT = 2'd2
  } alu_op_e;

  typedef enum logic [1:0] {
    BASE_NPC  = 2'd0,
    BASE_REG  = 2'd1,
    BASE_ZERO = 2'd2
  } base_sel_e;

  typedef enum logic [2:0] {
    OFF_NONE = 3'd0,
    OFF_6    = 3'd1,
    OFF_9    = 3'd2,
    OFF_11   = 3'd3,
    OFF_VEC  = 3'd4
  } off_sel_e;

  typedef struct packed {
    alu_op_e   alu_op;
    logic      op2_imm;
    logic      alu_wr;
    base_sel_e base;
    off_sel_e  off;
  } exec_ctl_t;

endpackage

// File: rtl/exec_decode.sv
module exec_decode
  import exec_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic       link_bit,
  input  logic       imm_bit,
  output exec_ctl_t  ctl
);

  always_comb begin
    ctl         = '0;
    ctl.alu_op  = ALU_ADD;
    ctl.op2_imm = 1'b0;
    ctl.alu_wr  = 1'b0;
    ctl.base    = BASE_NPC;
    ctl.off     = OFF_NONE;
    case (opcode)
      OPC_ADD: begin
        ctl.alu_op  = ALU_ADD;
        ctl.op2_imm = imm_bit;
        ctl.alu_wr  = 1'b1;
      end
      OPC_AND: begin
        ctl.alu_op  = ALU_AND;
        ctl.op2_imm = imm_bit;
        ctl.alu_wr  = 1'b1;
      end
      OPC_NOT: begin
        ctl.alu_op = ALU_NOT;
        ctl.alu_wr = 1'b1;
      end
      OPC_BR, OPC_LD, OPC_ST, OPC_LDI, OPC_STI, OPC_LEA: begin
        ctl.base = BASE_NPC;
        ctl.off  = OFF_9;
      end
      OPC_JSR: begin
        if (link_bit) begin
          ctl.base = BASE_NPC;
          ctl.off  = OFF_11;
        end else begin
          ctl.base = BASE_REG;
          ctl.off  = OFF_NONE;
        end
      end
      OPC_LDR, OPC_STR: begin
        ctl.base = BASE_REG;
        ctl.off  = OFF_6;
      end
      OPC_JMP: begin
        ctl.base = BASE_REG;
        ctl.off  = OFF_NONE;
      end
      OPC_TRAP: begin
        ctl.base = BASE_ZERO;
        ctl.off  = OFF_VEC;
      end
      default: begin
        ctl.base = BASE_NPC;
        ctl.off  = OFF_NONE;
      end
    endcase
  end

endmodule

// File: rtl/exec_ext.sv
module exec_ext
  import exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [10:0]       field,
  input  off_sel_e          sel,
  output logic [DATA_W-1:0] imm5_x,
  output logic [DATA_W-1:0] off_x
);

  localparam int NUM_SX = 4;
  localparam int VEC_W  = 8;

  logic [DATA_W-1:0] sx [NUM_SX];

  // signed fields of width 5, 6, 9 and 11 bits, all anchored at bit 0
  for (genvar g = 0; g < NUM_SX; g++) begin : g_sx
    localparam int FW = (g == 0) ? 5 : (g == 1) ? 6 : (g == 2) ? 9 : 11;
    assign sx[g] = {{(DATA_W-FW){field[FW-1]}}, field[FW-1:0]};
  end

  assign imm5_x = sx[0];

  always_comb begin
    case (sel)
      OFF_6:   off_x = sx[1];
      OFF_9:   off_x = sx[2];
      OFF_11:  off_x = sx[3];
      OFF_VEC: off_x = {{(DATA_W-VEC_W){1'b0}}, field[VEC_W-1:0]};
      default: off_x = '0;
    endcase
  end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_NOT: y = ~a;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/exec_stage.sv
module exec_stage
  import exec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IR_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IR_W-1:0]   ir,
  input  logic [DATA_W-1:0] vsr1,
  input  logic [DATA_W-1:0] vsr2,
  input  logic [DATA_W-1:0] npc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] aluout,
  output logic [DATA_W-1:0] pcout
);

  localparam int OPC_W   = 4;
  localparam int LINK_B  = 11;
  localparam int IMM_B   = 5;
  localparam int FIELD_W = 11;

  exec_ctl_t         ctl;
  logic [DATA_W-1:0] imm5_x;
  logic [DATA_W-1:0] off_x;
  logic [DATA_W-1:0] op2;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] target;
  logic              take;

  exec_decode u_dec (
    .opcode   (ir[IR_W-1 -: OPC_W]),
    .link_bit (ir[LINK_B]),
    .imm_bit  (ir[IMM_B]),
    .ctl      (ctl)
  );

  exec_ext #(.DATA_W(DATA_W)) u_ext (
    .field  (ir[FIELD_W-1:0]),
    .sel    (ctl.off),
    .imm5_x (imm5_x),
    .off_x  (off_x)
  );

  assign op2 = ctl.op2_imm ? imm5_x : vsr2;

  exec_alu #(.DATA_W(DATA_W)) u_alu (
    .a  (vsr1),
    .b  (op2),
    .op (ctl.alu_op),
    .y  (alu_y)
  );

  always_comb begin
    case (ctl.base)
      BASE_REG:  base = vsr1;
      BASE_ZERO: base = '0;
      default:   base = npc;
    endcase
  end

  assign target   = base + off_x;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      aluout    <= '0;
      pcout     <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      pcout     <= target;
      if (ctl.alu_wr) aluout <= alu_y;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

module exec_stage_chk #(
  parameter int DATA_W = 16,
  parameter int IR_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [IR_W-1:0]   ir,
  input logic [DATA_W-1:0] vsr1,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] aluout,
  input logic [DATA_W-1:0] pcout
);

  logic [3:0] opc;
  logic       alu_class;
  assign opc       = ir[IR_W-1 -: 4];
  assign alu_class = (opc == 4'h1) || (opc == 4'h5) || (opc == 4'h9);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(aluout) && $stable(pcout)));

  // R10
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R11
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R9
  alu_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !alu_class) |=> $stable(aluout));

  // R4
  invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && opc == 4'h9) |=> (aluout == ~$past(vsr1)));

  // R7
  jump_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && opc == 4'hC) |=> (pcout == $past(vsr1)));

endmodule

bind exec_stage exec_stage_chk #(.DATA_W(DATA_W), .IR_W(IR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .ir        (ir),
  .vsr1      (vsr1),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .aluout    (aluout),
  .pcout     (pcout)
);

// File: tb/exec_stage_test.sv
module exec_stage_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] ir = '0;
  logic [15:0] vsr1 = '0;
  logic [15:0] vsr2 = '0;
  logic [15:0] npc = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] aluout;
  logic [15:0] pcout;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic        m_ov = 1'b0;
  logic [15:0] m_alu = '0;
  logic [15:0] m_pc = '0;

  exec_stage uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .ir        (ir),
    .vsr1      (vsr1),
    .vsr2      (vsr2),
    .npc       (npc),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .aluout    (aluout),
    .pcout     (pcout)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] sx(input logic [15:0] v, input int w);
    logic signed [15:0] t;
    t = v << (16 - w);
    return t >>> (16 - w);
  endfunction

  function automatic logic [15:0] exp_alu(input logic [15:0] i, a, b, prev);
    logic [15:0] o2;
    o2 = i[5] ? sx(i, 5) : b;
    case (i[15:12])
      4'h1:    return a + o2;
      4'h5:    return a & o2;
      4'h9:    return ~a;
      default: return prev;
    endcase
  endfunction

  function automatic logic [15:0] exp_pc(input logic [15:0] i, a, n);
    case (i[15:12])
      4'h0, 4'h2, 4'h3, 4'hA, 4'hB, 4'hE: return n + sx(i, 9);
      4'h4:       return i[11] ? n + sx(i, 11) : a;
      4'h6, 4'h7: return a + sx(i, 6);
      4'hC:       return a;
      4'hF:       return {8'h00, i[7:0]};
      default:    return n;
    endcase
  endfunction

  function automatic string tag_of(input logic [15:0] i);
    case (i[15:12])
      4'h1: return "R2";
      4'h5: return "R3";
      4'h9: return "R4";
      4'h0, 4'h2, 4'h3, 4'hA, 4'hB, 4'hE: return "R5";
      4'h4: return "R6";
      4'h6, 4'h7, 4'hC: return "R7";
      4'hF: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic step(input string tag, input logic v, r,
                      input logic [15:0] i, a, b, n);
    logic acc;
    in_valid = v; out_ready = r; ir = i; vsr1 = a; vsr2 = b; npc = n;
    #1;
    chk("R10", "in_ready", {15'd0, in_ready}, {15'd0, (!m_ov || r)});
    acc = v && (!m_ov || r);
    @(posedge clk); #1;
    if (acc) begin
      m_alu = exp_alu(i, a, b, m_alu);
      m_pc  = exp_pc(i, a, n);
      m_ov  = 1'b1;
    end else if (r) begin
      m_ov = 1'b0;
    end
    chk(acc ? "R10" : (r ? "R11" : "R10"), "out_valid", {15'd0, out_valid}, {15'd0, m_ov});
    chk(tag, "aluout", aluout, m_alu);
    chk(tag, "pcout", pcout, m_pc);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0406));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid", {15'd0, out_valid}, 16'd0);
    chk("R1", "in_ready", {15'd0, in_ready}, 16'd1);
    chk("R1", "aluout", aluout, 16'h0000);
    chk("R1", "pcout", pcout, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: add, register and negative immediate
    step("R2", 1, 1, 16'h14C5, 16'h0005, 16'h0007, 16'h3001);
    step("R2", 1, 1, 16'h14F0, 16'h0003, 16'h1111, 16'h3002);
    // R3: and, register and immediate
    step("R3", 1, 1, 16'h54C5, 16'hF0F0, 16'hFF00, 16'h3003);
    step("R3", 1, 1, 16'h54EF, 16'hFFFF, 16'h0000, 16'h3004);
    // R4: invert
    step("R4", 1, 1, 16'h967F, 16'h1234, 16'hAAAA, 16'h3005);
    // R5: offset -1 from npc, aluout kept (R9)
    step("R5", 1, 1, 16'h0FFF, 16'h9999, 16'h8888, 16'h3001);
    step("R5", 1, 1, 16'hE010, 16'h0000, 16'h0000, 16'h3005);
    // R6: long offset -1024 and register form
    step("R6", 1, 1, 16'h4C00, 16'h7777, 16'h0000, 16'h3000);
    step("R6", 1, 1, 16'h4080, 16'h4567, 16'h0000, 16'h3000);
    // R7: jump via register and base + negative offset6
    step("R7", 1, 1, 16'hC1C0, 16'hABCD, 16'h0000, 16'h3000);
    step("R7", 1, 1, 16'h60A0, 16'h0100, 16'h0000, 16'h3000);
    // R8: zero-extended vector
    step("R8", 1, 1, 16'hF0A5, 16'h1234, 16'h0000, 16'h3000);
    // R9: unnamed opcode gives npc on pcout
    step("R9", 1, 1, 16'h8000, 16'h1234, 16'h5678, 16'h4242);

    // R10: back-pressure, the new instruction must not be taken
    step("R10", 1, 0, 16'h14C5, 16'h0001, 16'h0001, 16'h1000);
    step("R10", 1, 0, 16'h967F, 16'h0F0F, 16'h0000, 16'h2000);
    step("R10", 1, 0, 16'hF0FF, 16'h0F0F, 16'h0000, 16'h2000);
    // R11: drain with no new input
    step("R11", 0, 1, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    step("R11", 0, 1, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    // R10: take while empty without output ready
    step("R10", 1, 0, 16'h14C5, 16'h0010, 16'h0020, 16'h0100);

    for (int k = 0; k < 600; k++) begin
      logic [15:0] ri;
      logic        rv;
      logic        rr;
      ri = 16'($urandom);
      rv = ($urandom % 4) != 0;
      rr = ($urandom % 4) != 0;
      step(tag_of(ri), rv, rr, ri, 16'($urandom), 16'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule